// File: doc/BRIEF.md
# Serial ASCII Decimal to Binary Converter

This block turns a stream of decimal digit characters into an unsigned binary integer. Characters arrive one byte at a time with a valid/ready handshake, most significant digit first. A start pulse opens a new number. An end pulse closes it and produces a one-cycle done strobe with the final value.

Each accepted digit updates the running value to ten times its previous value plus the digit. The multiply by ten uses two shifts and one addition, so the block has no multiplier and no per-position tables. A digit's numeric value is taken by masking the character code. Any number of digits is accepted; the only limit is the accumulator width. Two sticky flags report an accumulator overflow and a non-digit character.

Top module: `ascii_dec_conv`

## Requirements
- R1: While reset is asserted and in the first cycle after it, value_o is 0 and done_o, overflow_o and invalid_o are 0. ready_o is 0 during reset.
- R2: An accepted character in 0x30..0x39 has digit value char[3:0]. In the cycle after it is accepted, value_o equals the previous value times ten plus that digit. For example, "456" gives 4, then 45, then 456.
- R3: ready_o is 1 in every cycle from the first clock edge after reset. A character is accepted in every cycle where char_valid_i and ready_o are both 1, including back-to-back cycles.
- R4: An accepted character outside 0x30..0x39 (for example 0x2F or 0x3A) leaves value_o unchanged. It sets invalid_o from the next cycle on, and invalid_o stays set until a start.
- R5: If ten times the value plus the digit exceeds 2^W-1, overflow_o is set from the next cycle and stays set until a start. value_o then keeps the low W bits of the result.
- R6: start_i clears value_o, overflow_o and invalid_o in the next cycle. A character accepted in the same cycle as start_i is treated as the first character of the new number.
- R7: done_o is 1 for exactly the one cycle after each end_i pulse. In that cycle value_o includes any digit accepted together with end_i. value_o is held after done until the next start or digit.
- R8: The digit count is unbounded. Any run of leading zeros leaves the value 0, and the digits that follow are accumulated normally.
- R9: A non-digit character accepted in the same cycle as start_i leaves value_o at 0 and invalid_o at 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new number; clears the value and both flags |
| char_valid_i | input | 1 | char_i holds a character |
| char_i | input | 8 | ASCII character |
| char_ready_o | output | 1 | Block accepts a character this cycle |
| end_i | input | 1 | Closes the current number |
| value_o | output | W | Running or final binary value |
| done_o | output | 1 | One-cycle strobe after end_i |
| overflow_o | output | 1 | Sticky overflow flag |
| invalid_o | output | 1 | Sticky non-digit flag |

## Verification
Two pairs of functions can fall in the same cycle: clearing a number and taking its first character, and closing a number and taking its last character. The bench drives start_i together with a digit or a non-digit, and end_i together with a digit. A behavioural model applies the clear before the character and folds the last digit into the final value, and it is compared with the outputs every clock. Overflow is also provoked on the digit that closes a number, so that the flag and done_o appear in the same cycle.

// File: rtl/ascii_dec_pkg.sv
package ascii_dec_pkg;
  localparam logic [3:0] DIGIT_ZONE = 4'h3;
  localparam logic [3:0] DIGIT_MAX  = 4'd9;

  typedef struct packed {
    logic       ok;
    logic [3:0] val;
  } digit_t;
endpackage

// File: rtl/ascii_digit_decode.sv
module ascii_digit_decode
  import ascii_dec_pkg::*;
(
  input  logic [7:0] char_i,
  output digit_t     dig_o
);
  // value by masking; legal only for the digit zone and 0..9
  always_comb begin
    dig_o.val = char_i[3:0];
    dig_o.ok  = (char_i[7:4] == DIGIT_ZONE) && (char_i[3:0] <= DIGIT_MAX);
  end

  always_comb begin
    if (!$isunknown(char_i)) begin
      // R2
      digit_range_chk: assert (!dig_o.ok || (char_i >= 8'h30 && char_i <= 8'h39));
    end
  end
endmodule

// File: rtl/ascii_mul10.sv
module ascii_mul10 #(
  parameter int W = 32
) (
  input  logic [W-1:0] n_i,
  output logic [W+3:0] prod_o
);
  localparam int PW = W + 4;

  logic [PW-1:0] n_ext;
  logic [PW-1:0] quad;
  logic [PW-1:0] five;

  // (4n + n) * 2
  always_comb begin
    n_ext  = {4'b0, n_i};
    quad   = n_ext << 2;
    five   = quad + n_ext;
    prod_o = five << 1;
  end

  always_comb begin
    if (!$isunknown(n_i)) begin
      // R2
      mul10_chk: assert (prod_o == n_ext * PW'(10));
    end
  end
endmodule

// File: rtl/ascii_acc_unit.sv
module ascii_acc_unit #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         take_i,
  input  logic         bad_i,
  input  logic [3:0]   digit_i,
  input  logic         end_i,
  output logic [W-1:0] acc_o,
  output logic         ovf_o,
  output logic         inv_o,
  output logic         done_o
);
  localparam int SW = W + 5;

  logic [W-1:0]  acc_q;
  logic          ovf_q, inv_q, done_q;
  logic [W-1:0]  base;
  logic [W+3:0]  prod;
  logic [SW-1:0] sum;
  logic          sum_ovf;

  assign base = start_i ? '0 : acc_q;

  ascii_mul10 #(.W(W)) u_mul10 (
    .n_i   (base),
    .prod_o(prod)
  );

  always_comb begin
    sum     = {1'b0, prod} + {{(SW-4){1'b0}}, digit_i};
    sum_ovf = |sum[SW-1:W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      ovf_q  <= 1'b0;
      inv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (take_i) begin
        acc_q <= sum[W-1:0];
        ovf_q <= (ovf_q & ~start_i) | sum_ovf;
      end else if (start_i) begin
        acc_q <= '0;
        ovf_q <= 1'b0;
      end
      inv_q  <= (inv_q & ~start_i) | bad_i;
      done_q <= end_i;
    end
  end

  assign acc_o  = acc_q;
  assign ovf_o  = ovf_q;
  assign inv_o  = inv_q;
  assign done_o = done_q;

  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !start_i |=> ovf_q);
  // R4
  inv_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_q && !start_i |=> inv_q);
  // R6
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !take_i && !bad_i |=> acc_q == '0 && !ovf_q && !inv_q);
  // R2
  acc_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !start_i |=> ovf_q || acc_q >= $past(acc_q));
  // R4
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i && !start_i |=> acc_q == $past(acc_q));
endmodule

// File: rtl/ascii_dec_conv.sv
module ascii_dec_conv
  import ascii_dec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         char_valid_i,
  input  logic [7:0]   char_i,
  output logic         char_ready_o,
  input  logic         end_i,
  output logic [W-1:0] value_o,
  output logic         done_o,
  output logic         overflow_o,
  output logic         invalid_o
);
  logic   rdy_q;
  logic   accept, take, bad;
  digit_t dig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= 1'b1;
  end

  ascii_digit_decode u_dec (
    .char_i(char_i),
    .dig_o (dig)
  );

  assign accept = char_valid_i & rdy_q;
  assign take   = accept & dig.ok;
  assign bad    = accept & ~dig.ok;

  ascii_acc_unit #(.W(W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .take_i (take),
    .bad_i  (bad),
    .digit_i(dig.val),
    .end_i  (end_i),
    .acc_o  (value_o),
    .ovf_o  (overflow_o),
    .inv_o  (invalid_o),
    .done_o (done_o)
  );

  assign char_ready_o = rdy_q;

  // R3
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_ready_o |=> char_ready_o);
  // R7
  done_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> done_o);
endmodule

// File: tb/ascii_dec_conv_bench.sv
module ascii_dec_conv_bench;
  localparam int W = 32;
  localparam longint MASK = (64'd1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, cvalid = 1'b0, endp = 1'b0;
  logic [7:0]   ch = 8'h00;
  logic         rdy, done, ovf, inv;
  logic [W-1:0] val;

  int checks = 0;
  int failures = 0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  ascii_dec_conv #(.W(W)) u_ascii_dec_conv (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .char_valid_i(cvalid),
    .char_i(ch), .char_ready_o(rdy), .end_i(endp), .value_o(val),
    .done_o(done), .overflow_o(ovf), .invalid_o(inv)
  );

  // behavioural reference
  longint m_val;
  bit m_ovf, m_inv, m_done, m_rdy;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val = 0; m_ovf = 0; m_inv = 0; m_done = 0; m_rdy = 0;
    end else begin
      longint nv;
      if (start) begin m_val = 0; m_ovf = 0; m_inv = 0; end
      if (cvalid && m_rdy) begin
        if (ch >= 8'h30 && ch <= 8'h39) begin
          nv = m_val * 10 + longint'(ch - 8'h30);
          if (nv > MASK) m_ovf = 1;
          m_val = nv & MASK;
        end else m_inv = 1;
      end
      m_done = endp;
      m_rdy = 1;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R2", "value", longint'(val), m_val);
      chk("R5", "overflow", longint'(ovf), longint'(m_ovf));
      chk("R4", "invalid", longint'(inv), longint'(m_inv));
      chk("R7", "done", longint'(done), longint'(m_done));
      chk("R3", "ready", longint'(rdy), longint'(m_rdy));
    end
  end

  // drive after a falling edge, return after the next falling edge
  task automatic cyc(bit v, logic [7:0] c, bit st, bit en);
    cvalid = v; ch = c; start = st; endp = en;
    @(posedge clk);
    @(negedge clk);
    cvalid = 0; start = 0; endp = 0;
  endtask

  task automatic put_str(string s);
    for (int i = 0; i < s.len(); i++) cyc(1, s[i], 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 during reset
    chk("R1", "ready in reset", longint'(rdy), 0);
    chk("R1", "value in reset", longint'(val), 0);
    chk("R1", "flags in reset", longint'({done, ovf, inv}), 0);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    chk("R1", "value after reset", longint'(val), 0);
    chk("R3", "ready after reset", longint'(rdy), 1);

    // R2 "456" back to back
    cyc(1, "4", 1, 0); chk("R2", "after 4", longint'(val), 4);
    cyc(1, "5", 0, 0); chk("R2", "after 45", longint'(val), 45);
    cyc(1, "6", 0, 0); chk("R2", "after 456", longint'(val), 456);
    cyc(0, 8'h00, 0, 1); chk("R7", "done 456", longint'({done, val == 456}), 3);
    cyc(0, 8'h00, 0, 0); chk("R7", "done single cycle", longint'(done), 0);
    chk("R7", "value held", longint'(val), 456);

    // R3 gap then continue
    cyc(1, "1", 1, 0); cyc(0, "9", 0, 0); cyc(1, "2", 0, 0);
    chk("R3", "gap ignored", longint'(val), 12);

    // R4 invalid mid-number, both boundaries
    cyc(1, 8'h3A, 0, 0);
    chk("R4", "colon value", longint'(val), 12);
    chk("R4", "colon flag", longint'(inv), 1);
    cyc(1, 8'h2F, 0, 0); cyc(1, "3", 0, 0);
    chk("R4", "flag sticky", longint'({inv, val == 123}), 3);

    // R6 start with digit in same cycle
    cyc(1, "9", 1, 0);
    chk("R6", "start+digit", longint'(val), 9);
    chk("R6", "flags cleared", longint'({ovf, inv}), 0);
    cyc(0, 8'h00, 1, 0);
    chk("R6", "start alone", longint'(val), 0);

    // R7 end with digit in same cycle
    put_str("7");
    cyc(1, "8", 0, 1);
    chk("R7", "end+digit", longint'({done, val == 78}), 3);

    // R5 max value, no overflow
    cyc(0, 8'h00, 1, 0);
    put_str("4294967295");
    chk("R5", "max no overflow", longint'({ovf, val == 32'hFFFFFFFF}), 1);
    // R5 overflow on closing digit, wraps
    cyc(0, 8'h00, 1, 0);
    put_str("429496729");
    cyc(1, "6", 0, 1);
    chk("R5", "overflow wrap", longint'({ovf, done, val == 0}), 7);
    put_str("55");
    chk("R5", "overflow sticky", longint'(ovf), 1);

    // R8 long zero run
    cyc(0, 8'h00, 1, 0);
    for (int i = 0; i < 40; i++) cyc(1, "0", 0, 0);
    chk("R8", "zeros", longint'(val), 0);
    put_str("12");
    chk("R8", "after zeros", longint'({ovf, val == 12}), 1);

    // R9 start with non-digit
    cyc(1, "/", 1, 0);
    chk("R9", "start+bad value", longint'(val), 0);
    chk("R9", "start+bad flag", longint'(inv), 1);

    // pseudo-random mix vs model
    for (int i = 0; i < 400; i++) begin
      int r = (i * 37 + 11) % 29;
      logic [7:0] c = (r < 20) ? 8'(8'h30 + r % 10) : 8'(8'h28 + r);
      cyc(r != 3, c, (i % 23) == 0, (i % 17) == 5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule